// File: doc/BRIEF.md
# Configurable Crosspoint I/O Cell

This block is one programmable cell at the edge of a signal routing crosspoint. Four routed data inputs feed a 4:1 multiplexer. Its 2-bit select follows a Gray-coded order. One storage element can be placed in one of two paths. In the outbound path it sits between the multiplexer and the pad output. In the inbound path it sits between the pad input and the feedback line into the routing pool. The storage element can also be taken out of both paths, which leaves a purely combinational cell.

A configuration word sets how the cell behaves. It chooses one of three storage modes: bypass, edge register or transparent latch. It also chooses which path holds the storage element, which of two candidate clocks is used and its polarity, which of two candidate enables is used and its polarity, and the polarity of the pad output. The whole cell runs on one system clock `clk`. The candidate clocks and enables are sampled as ordinary inputs. An "edge" of the effective clock is a change from low to high seen between two consecutive system clock edges. The data path is a bit-level crosspoint with no transfer handshake, so every pin is a plain level.

Top module: `xcell_top`

## Requirements
- R1: With `sel` = 00 the multiplexer picks `din_0`, with 01 it picks `din_1`, with 11 it picks `din_2` and with 10 it picks `din_3`.
- R2: When `cfg_load` is high at a clock edge, `cfg_word` is stored and takes effect from that edge on. The word's fields are: bits[1:0] mode (00 bypass, 01 register, 10 latch, 11 bypass), bit2 path (0 = outbound, 1 = inbound), bit3 clock select (0 = `clk_a`, 1 = `clk_b`), bit4 clock invert, bit5 enable select (0 = `en_a`, 1 = `en_b`), bit6 enable invert and bit7 pad output invert.
- R3: In bypass mode, `pad_out` is the multiplexer output XOR the output invert bit, and `fb_out` equals `pad_in`. Both are combinational.
- R4: In register mode on the outbound path, the multiplexer output is captured at a rising edge of the effective clock while the effective enable is high. `pad_out` shows the stored bit XOR the output invert bit, and `fb_out` equals `pad_in`.
- R5: In register mode on the inbound path, `pad_in` is captured under the same edge and enable rule and shown on `fb_out`. `pad_out` is the multiplexer output XOR the output invert bit.
- R6: The effective enable is the selected enable input XOR the enable invert bit. With the effective enable low, the register keeps its value across clock edges.
- R7: The effective clock is the selected clock input XOR the clock invert bit. A capture happens only in a system cycle where the effective clock is high and was low at the previous system clock edge.
- R8: In latch mode, while the effective clock is high, the path output follows the storage input at once. While the effective clock is low, the path output holds the value sampled at the last system clock edge at which the effective clock was high. The enable does not act on the latch.
- R9: The output invert bit acts only on `pad_out` and never on `fb_out`, in every mode.
- R10: A synchronous `rst` clears the stored bit to 0 and sets the configuration to all zeros: bypass, outbound path, all polarities active high. `rst` takes priority over `cfg_load`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Store `cfg_word` at this edge |
| cfg_word | input | 8 | Configuration word, field layout in R2 |
| din_0 | input | DW | Routed data input, code 00 |
| din_1 | input | DW | Routed data input, code 01 |
| din_2 | input | DW | Routed data input, code 11 |
| din_3 | input | DW | Routed data input, code 10 |
| sel | input | 2 | Gray-coded multiplexer select |
| pad_in | input | DW | Value arriving from the pad |
| clk_a | input | 1 | Candidate storage clock, I/O-derived |
| clk_b | input | 1 | Candidate storage clock, dedicated |
| en_a | input | 1 | Candidate enable, I/O-derived |
| en_b | input | 1 | Candidate enable, global |
| pad_out | output | DW | Value driven toward the pad |
| fb_out | output | DW | Feedback into the routing pool |

## Verification
The bench walks through all 256 configuration words and drives pseudo-random clocks, enables, selects and data under each one. A step-by-step model of the requirements predicts both outputs. This model catches several likely faults. A binary-ordered select would swap the `din_2` and `din_3` picks. A level-sensitive register would capture again while the clock stays high. An inverted polarity bit or a swapped source select would capture on the wrong cycles. An output invert that leaks onto `fb_out` would flip feedback bits. A latch that waited for an edge would lag its input by a cycle. Directed steps check that reset clears the stored bit with a pending load, and that all four Gray codes pick the right input.

// File: rtl/xcell_pkg.sv
package xcell_pkg;

  typedef enum logic [1:0] {
    MODE_BYPASS  = 2'b00,
    MODE_REG     = 2'b01,
    MODE_LATCH   = 2'b10,
    MODE_BYPASS2 = 2'b11
  } store_mode_e;

  typedef struct packed {
    logic        out_inv;
    logic        en_inv;
    logic        en_sel;
    logic        clk_inv;
    logic        clk_sel;
    logic        path_in;
    store_mode_e mode;
  } cell_cfg_t;

  localparam int CFG_W = $bits(cell_cfg_t);

endpackage

// File: rtl/xcell_gray_mux.sv
module xcell_gray_mux #(
  parameter int DW = 1
) (
  input  logic [DW-1:0] leg [4],
  input  logic [1:0]    code,
  output logic [DW-1:0] picked
);
  localparam int IW = 2;

  logic [IW-1:0] index;

  // Gray order: 00,01,11,10 map to legs 0,1,2,3
  always_comb begin
    index  = {code[1], code[1] ^ code[0]};
    picked = leg[index];
  end
endmodule

// File: rtl/xcell_clk_ctrl.sv
module xcell_clk_ctrl (
  input  logic clk,
  input  logic clk_a,
  input  logic clk_b,
  input  logic en_a,
  input  logic en_b,
  input  logic clk_sel,
  input  logic clk_inv,
  input  logic en_sel,
  input  logic en_inv,
  output logic eff_clk,
  output logic eff_en,
  output logic rise
);
  logic eff_prev;

  always_comb begin
    eff_clk = (clk_sel ? clk_b : clk_a) ^ clk_inv;
    eff_en  = (en_sel ? en_b : en_a) ^ en_inv;
    rise    = eff_clk & ~eff_prev;
  end

  // tracks the effective clock even during reset so release makes no false edge
  always_ff @(posedge clk) begin
    eff_prev <= eff_clk;
  end
endmodule

// File: rtl/xcell_store.sv
module xcell_store #(
  parameter int DW = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          as_reg,
  input  logic          as_latch,
  input  logic          eff_clk,
  input  logic          fire,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic [DW-1:0] y
);
  logic open_latch;

  always_comb begin
    open_latch = as_latch & eff_clk;
    y          = open_latch ? d : q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (as_reg && fire) begin
      q <= d;
    end else if (open_latch) begin
      q <= d;
    end
  end
endmodule

// File: rtl/xcell_top.sv
module xcell_top
  import xcell_pkg::*;
#(
  parameter int DW = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_load,
  input  logic [CFG_W-1:0] cfg_word,
  input  logic [DW-1:0]    din_0,
  input  logic [DW-1:0]    din_1,
  input  logic [DW-1:0]    din_2,
  input  logic [DW-1:0]    din_3,
  input  logic [1:0]       sel,
  input  logic [DW-1:0]    pad_in,
  input  logic             clk_a,
  input  logic             clk_b,
  input  logic             en_a,
  input  logic             en_b,
  output logic [DW-1:0]    pad_out,
  output logic [DW-1:0]    fb_out
);
  cell_cfg_t     cfg_q;
  logic [DW-1:0] legs [4];
  logic [DW-1:0] mux_out;
  logic          eff_clk, eff_en, eff_rise, cap_fire;
  logic          as_reg, as_latch, stored;
  logic [DW-1:0] store_d, store_q, store_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
    end else if (cfg_load) begin
      cfg_q <= cell_cfg_t'(cfg_word);
    end
  end

  always_comb begin
    legs[0] = din_0;
    legs[1] = din_1;
    legs[2] = din_2;
    legs[3] = din_3;
  end

  xcell_gray_mux #(.DW(DW)) u_mux (
    .leg    (legs),
    .code   (sel),
    .picked (mux_out)
  );

  xcell_clk_ctrl u_clk (
    .clk     (clk),
    .clk_a   (clk_a),
    .clk_b   (clk_b),
    .en_a    (en_a),
    .en_b    (en_b),
    .clk_sel (cfg_q.clk_sel),
    .clk_inv (cfg_q.clk_inv),
    .en_sel  (cfg_q.en_sel),
    .en_inv  (cfg_q.en_inv),
    .eff_clk (eff_clk),
    .eff_en  (eff_en),
    .rise    (eff_rise)
  );

  always_comb begin
    as_reg   = (cfg_q.mode == MODE_REG);
    as_latch = (cfg_q.mode == MODE_LATCH);
    stored   = as_reg | as_latch;
    cap_fire = eff_rise & eff_en;
    store_d  = cfg_q.path_in ? pad_in : mux_out;
  end

  xcell_store #(.DW(DW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .as_reg   (as_reg),
    .as_latch (as_latch),
    .eff_clk  (eff_clk),
    .fire     (cap_fire),
    .d        (store_d),
    .q        (store_q),
    .y        (store_out)
  );

  always_comb begin
    pad_out = ((stored && !cfg_q.path_in) ? store_out : mux_out) ^ {DW{cfg_q.out_inv}};
    fb_out  = (stored && cfg_q.path_in) ? store_out : pad_in;
  end
endmodule

// File: rtl/xcell_checker.sv
module xcell_checker
  import xcell_pkg::*;
#(
  parameter int DW = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_load,
  input cell_cfg_t     cfg,
  input logic          eff_clk,
  input logic          cap_fire,
  input logic [DW-1:0] store_d,
  input logic [DW-1:0] store_q,
  input logic [DW-1:0] pad_in,
  input logic [DW-1:0] pad_out,
  input logic [DW-1:0] fb_out
);
  p_rst_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (store_q == '0 && cfg == '0));

  p_bypass_fb_r3: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode != MODE_REG && cfg.mode != MODE_LATCH) |-> fb_out == pad_in);

  p_reg_capture_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_REG && !cfg.path_in && cap_fire && !cfg_load)
      |=> pad_out == ($past(store_d) ^ {DW{cfg.out_inv}}));

  p_reg_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_REG && !cap_fire && !cfg_load) |=> $stable(store_q));

  p_latch_track_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg.mode == MODE_LATCH && eff_clk && !cfg_load) |=> store_q == $past(store_d));
endmodule

bind xcell_top xcell_checker #(.DW(DW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cfg_load (cfg_load),
  .cfg      (cfg_q),
  .eff_clk  (eff_clk),
  .cap_fire (cap_fire),
  .store_d  (store_d),
  .store_q  (store_q),
  .pad_in   (pad_in),
  .pad_out  (pad_out),
  .fb_out   (fb_out)
);

// File: tb/xcell_top_bench.sv
module xcell_top_bench;
  logic       clk = 1'b0;
  logic       rst, cfg_load;
  logic [7:0] cfg_word;
  logic       din_0, din_1, din_2, din_3, pad_in;
  logic [1:0] sel;
  logic       clk_a, clk_b, en_a, en_b;
  logic       pad_out, fb_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference state, built from the requirements
  logic [7:0]  m_cfg;
  logic        m_q, m_prev;
  logic [15:0] lfsr = 16'hACE1;

  always #5 clk = ~clk;

  xcell_top u_xcell_top (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_word(cfg_word),
    .din_0(din_0), .din_1(din_1), .din_2(din_2), .din_3(din_3),
    .sel(sel), .pad_in(pad_in), .clk_a(clk_a), .clk_b(clk_b),
    .en_a(en_a), .en_b(en_b), .pad_out(pad_out), .fb_out(fb_out)
  );

  function automatic logic gray_pick(logic [1:0] s, logic a, logic b, logic c, logic d);
    case (s)  // R1 table
      2'b00:   return a;
      2'b01:   return b;
      2'b11:   return c;
      default: return d;
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b cfg=%h t=%0t", tag, act, exp, m_cfg, $time);
    end
  endtask

  task automatic tick(bit do_check);
    logic eff, en, mux, d, sto, pexp, fexp, is_reg, is_lat;
    string base, ptag, ftag;
    #1;
    eff    = (m_cfg[3] ? clk_b : clk_a) ^ m_cfg[4];   // R7
    en     = (m_cfg[5] ? en_b : en_a) ^ m_cfg[6];     // R6
    is_reg = (m_cfg[1:0] == 2'b01);
    is_lat = (m_cfg[1:0] == 2'b10);
    mux    = gray_pick(sel, din_0, din_1, din_2, din_3);
    d      = m_cfg[2] ? pad_in : mux;
    sto    = (is_lat && eff) ? d : m_q;
    pexp   = (((is_reg || is_lat) && !m_cfg[2]) ? sto : mux) ^ m_cfg[7];
    fexp   = ((is_reg || is_lat) && m_cfg[2]) ? sto : pad_in;
    if (is_lat)      base = "R8";
    else if (is_reg) base = m_cfg[2] ? "R5" : "R4";
    else             base = "R3";
    ptag = m_cfg[7] ? "R9" : base;
    ftag = base;
    if (is_reg && m_cfg[6]) ftag = "R6";
    else if (is_reg && m_cfg[4]) ftag = "R7";
    if (do_check && !rst) begin
      check(ptag, pad_out, pexp);
      check(ftag, fb_out, fexp);
    end
    @(posedge clk);
    if (rst) begin
      m_q   = 1'b0;
      m_cfg = 8'h00;
    end else begin
      if (is_reg && eff && !m_prev && en) m_q = d;
      else if (is_lat && eff)              m_q = d;
      if (cfg_load) m_cfg = cfg_word;     // R2
    end
    m_prev = eff;
    #1;
  endtask

  task automatic scramble();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    {din_0, din_1, din_2, din_3, sel, pad_in} = lfsr[6:0];
    clk_a = lfsr[7] ^ lfsr[11];
    clk_b = lfsr[8] ^ lfsr[14];
    en_a  = lfsr[9] | lfsr[3];
    en_b  = lfsr[10] | lfsr[12];
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cfg_load = 1'b0; cfg_word = 8'h00;
    {din_0, din_1, din_2, din_3, sel, pad_in} = '0;
    {clk_a, clk_b, en_a, en_b} = '0;
    m_cfg = 8'h00; m_q = 1'b0; m_prev = 1'b0;
    repeat (3) tick(1'b0);

    // R10: reset beats a pending load; stored bit reads 0 through the inbound register
    cfg_load = 1'b1; cfg_word = 8'h85;
    tick(1'b0);
    rst = 1'b0; cfg_word = 8'h05;
    tick(1'b0);
    cfg_load = 1'b0; pad_in = 1'b1;
    #1; check("R10", fb_out, 1'b0);
    tick(1'b1);
    rst = 1'b1; tick(1'b0); rst = 1'b0;
    #1; check("R10", pad_out, din_0);
    check("R10", fb_out, pad_in);

    // R1: every code against every data pattern in bypass
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 16; p++) begin
        sel = s[1:0];
        {din_3, din_2, din_1, din_0} = p[3:0];
        #1;
        check("R1", pad_out, gray_pick(sel, din_0, din_1, din_2, din_3));
      end
    end

    // sweep every configuration word with pseudo-random stimulus
    for (int c = 0; c < 256; c++) begin
      cfg_load = 1'b1; cfg_word = c[7:0];
      tick(1'b1);
      cfg_load = 1'b0;
      for (int k = 0; k < 30; k++) begin
        scramble();
        tick(1'b1);
      end
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule